// File: doc/BRIEF.md
# Synchronized ADC Acquisition Sequencer

This block runs a multi-channel analog acquisition board with no processor in the loop. A sampling pulse that is shared across the whole network starts each acquisition group. The sequencer then visits every channel in ascending order. For each one it drives the channel select, gives the converter a one-cycle start strobe, waits for the converter's data-ready and pushes the zero-extended sample into an external FIFO. The FIFO interface has only a write strobe and a data word, with no address.

While the group runs, the block folds every word it writes into a 16-bit CRC. It writes the check word into the same FIFO after the last channel, so the reader on the bus side gets a one-way stream in a fixed order: the samples first, then the check word. It can throw away the group if the check word does not match. Status outputs show the current sequencer step, mirror the FIFO full flag and mark the end of a group. Sticky flags record dropped writes, ignored triggers and converter timeouts.

Top module: `acq_sequencer`

## Requirements
- R1: A group starts only when `sync_pulse` is sampled high while the sequencer is idle. At the next clock edge `stat_state` moves from 0 (idle) to 1 (select). Without a pulse the block stays idle and writes nothing.
- R2: The block handles channels 0 to NUM_CH-1 in ascending order. For each channel `stat_state` steps through 1 (select, one cycle), 2 (start, one cycle, `adc_start` high, `adc_ch_sel` equal to the channel), 3 (wait) and 4 (store, one cycle).
- R3: In the store step, when `fifo_full` is low, `fifo_wr` is high for exactly one cycle. `fifo_data` then holds the sample latched at data-ready, zero-extended from SAMPLE_W to WORD_W bits. No other step writes a sample.
- R4: After the last channel, step 5 (check word) writes the CRC for one cycle. The CRC starts at 0xFFFF for every group, uses polynomial 0x1021, is fed MSB first with each 16-bit word actually written, and has no final inversion.
- R5: `stat_state` uses the step codes 0 to 5 given above. `stat_fifo_full` always equals `fifo_full`.
- R6: A write that is due while `fifo_full` is high is dropped. This applies to a sample or to the check word. The block raises no strobe, leaves the CRC unchanged and sets `stat_overflow`, which stays set until reset.
- R7: `stat_group_done` goes high when the check-word step completes. The next pulse that starts a group clears it.
- R8: A `sync_pulse` that arrives while the sequencer is not idle does not change the group in progress, and it sets `stat_missed`, which stays set until reset.
- R9: The wait step lasts at most TIMEOUT_CYC cycles. A data-ready in the TIMEOUT_CYC-th wait cycle is still accepted. If none arrives by then, `stat_timeout` is set and stays set until reset, the block returns to idle without writing a check word, and `stat_group_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pulse | input | 1 | Network-wide sampling trigger |
| adc_ch_sel | output | CH_W | Selected analog channel |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_ready | input | 1 | Converter result valid |
| adc_data | input | SAMPLE_W | Converter result |
| fifo_full | input | 1 | Output FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | WORD_W | Word written to the FIFO |
| stat_fifo_full | output | 1 | FIFO full status |
| stat_state | output | 3 | Current sequencer step code |
| stat_group_done | output | 1 | Group completed with check word |
| stat_overflow | output | 1 | Sticky: a write was dropped |
| stat_missed | output | 1 | Sticky: a trigger was ignored |
| stat_timeout | output | 1 | Sticky: a conversion timed out |

## Verification
The bench builds the sequencer with five channels and a timeout of ten cycles. Five channels is not a power of two, so the last-channel detection is tested on a select field that has unused codes. The short timeout makes the exact timeout boundary cheap to reach: the bench has a conversion answer on the last allowed wait cycle and another conversion never answer. Per-channel converter latencies and a FIFO-full window that the bench places on one chosen channel or on the check word bring each drop and abort path within reach in a few hundred cycles.

// File: rtl/acq_pkg.sv
package acq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SELECT = 3'd1,
      ST_START  = 3'd2,
      ST_WAIT   = 3'd3,
      ST_STORE  = 3'd4,
      ST_CHECK  = 3'd5
   } acq_state_e;

endpackage

// File: rtl/acq_crc_step.sv
module acq_crc_step #(
   parameter int                CRC_W  = 16,
   parameter int                DATA_W = 16,
   parameter logic [CRC_W-1:0]  POLY   = 16'h1021
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);

   logic fb;

   // Bit-serial update, MSB first, unrolled over the data word
   always_comb begin
      crc_out = crc_in;
      fb      = 1'b0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb      = crc_out[CRC_W-1] ^ data_in[i];
         crc_out = {crc_out[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   end

endmodule

// File: rtl/acq_wait_timer.sv
module acq_wait_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   localparam int CNT_W = $clog2(LIMIT + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run && !expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/acq_word_fmt.sv
module acq_word_fmt #(
   parameter int SAMPLE_W = 12,
   parameter int WORD_W   = 16
) (
   input  logic [SAMPLE_W-1:0] sample,
   output logic [WORD_W-1:0]   word
);

   generate
      if (SAMPLE_W == WORD_W) begin : g_direct
         assign word = sample;
      end else begin : g_zext
         assign word = {{(WORD_W - SAMPLE_W){1'b0}}, sample};
      end
   endgenerate

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
   parameter int                 NUM_CH      = 8,
   parameter int                 SAMPLE_W    = 12,
   parameter int                 WORD_W      = 16,
   parameter int                 TIMEOUT_CYC = 64,
   parameter logic [WORD_W-1:0]  CRC_POLY    = 16'h1021,
   parameter logic [WORD_W-1:0]  CRC_INIT    = 16'hFFFF,
   localparam int                CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sync_pulse,
   output logic [CH_W-1:0]     adc_ch_sel,
   output logic                adc_start,
   input  logic                adc_ready,
   input  logic [SAMPLE_W-1:0] adc_data,
   input  logic                fifo_full,
   output logic                fifo_wr,
   output logic [WORD_W-1:0]   fifo_data,
   output logic                stat_fifo_full,
   output logic [2:0]          stat_state,
   output logic                stat_group_done,
   output logic                stat_overflow,
   output logic                stat_missed,
   output logic                stat_timeout
);

   import acq_pkg::*;

   // Elaboration-time parameter checks
   generate
      if (SAMPLE_W < 1 || SAMPLE_W > WORD_W) begin : g_bad_width
         $error("acq_sequencer: SAMPLE_W must be in 1..WORD_W");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("acq_sequencer: NUM_CH must be at least 1");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_tmo
         $error("acq_sequencer: TIMEOUT_CYC must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("acq_sequencer: WORD_W must be at least 2");
      end
   endgenerate

   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   acq_state_e          state_q;
   logic [CH_W-1:0]     ch_q;
   logic [SAMPLE_W-1:0] sample_q;
   logic [WORD_W-1:0]   crc_q;
   logic [WORD_W-1:0]   crc_next;
   logic [WORD_W-1:0]   sample_word;
   logic                done_q;
   logic                ovf_q;
   logic                miss_q;
   logic                tmo_q;
   logic                wait_expired;
   logic                last_ch;
   logic                write_due;

   acq_word_fmt #(
      .SAMPLE_W (SAMPLE_W),
      .WORD_W   (WORD_W)
   ) u_fmt (
      .sample (sample_q),
      .word   (sample_word)
   );

   acq_crc_step #(
      .CRC_W  (WORD_W),
      .DATA_W (WORD_W),
      .POLY   (CRC_POLY)
   ) u_crc (
      .crc_in  (crc_q),
      .data_in (sample_word),
      .crc_out (crc_next)
   );

   acq_wait_timer #(
      .LIMIT (TIMEOUT_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q == ST_START),
      .run     (state_q == ST_WAIT),
      .expired (wait_expired)
   );

   assign last_ch = (ch_q == LAST_CH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ch_q     <= '0;
         sample_q <= '0;
         crc_q    <= CRC_INIT;
         done_q   <= 1'b0;
         ovf_q    <= 1'b0;
         miss_q   <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         if (sync_pulse && state_q != ST_IDLE) begin
            miss_q <= 1'b1;
         end
         case (state_q)
            ST_IDLE: begin
               if (sync_pulse) begin
                  state_q <= ST_SELECT;
                  ch_q    <= '0;
                  crc_q   <= CRC_INIT;
                  done_q  <= 1'b0;
               end
            end
            ST_SELECT: state_q <= ST_START;
            ST_START:  state_q <= ST_WAIT;
            ST_WAIT: begin
               if (adc_ready) begin
                  sample_q <= adc_data;
                  state_q  <= ST_STORE;
               end else if (wait_expired) begin
                  tmo_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_STORE: begin
               if (fifo_full) begin
                  ovf_q <= 1'b1;
               end else begin
                  crc_q <= crc_next;
               end
               if (last_ch) begin
                  state_q <= ST_CHECK;
               end else begin
                  ch_q    <= ch_q + 1'b1;
                  state_q <= ST_SELECT;
               end
            end
            ST_CHECK: begin
               if (fifo_full) begin
                  ovf_q <= 1'b1;
               end
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign write_due       = (state_q == ST_STORE) || (state_q == ST_CHECK);
   assign fifo_wr         = write_due && !fifo_full;
   assign fifo_data       = (state_q == ST_CHECK) ? crc_q : sample_word;
   assign adc_start       = (state_q == ST_START);
   assign adc_ch_sel      = ch_q;
   assign stat_fifo_full  = fifo_full;
   assign stat_state      = state_q;
   assign stat_group_done = done_q;
   assign stat_overflow   = ovf_q;
   assign stat_missed     = miss_q;
   assign stat_timeout    = tmo_q;

endmodule

// File: rtl/acq_sequencer_checker.sv
module acq_sequencer_checker #(
   parameter int NUM_CH      = 8,
   parameter int TIMEOUT_CYC = 64,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int WC_W       = $clog2(TIMEOUT_CYC + 2)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sync_pulse,
   input logic [CH_W-1:0] adc_ch_sel,
   input logic            adc_start,
   input logic            fifo_full,
   input logic            fifo_wr,
   input logic [2:0]      stat_state,
   input logic            stat_group_done,
   input logic            stat_overflow,
   input logic            stat_missed,
   input logic            stat_timeout
);

   logic [WC_W-1:0] wait_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= '0;
      end else if (stat_state == 3'd3) begin
         wait_cnt <= wait_cnt + 1'b1;
      end else begin
         wait_cnt <= '0;
      end
   end

   AST_IDLE_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state == 3'd0 && sync_pulse) |=> (stat_state == 3'd1)); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state == 3'd0 && !sync_pulse) |=> (stat_state == 3'd0)); // R1

   AST_START_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> ($past(stat_state) == 3'd1)); // R2

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start); // R2

   AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> (int'(adc_ch_sel) < NUM_CH)); // R2

   AST_WRITE_IN_OUTPUT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> (stat_state == 3'd4 || stat_state == 3'd5)); // R3

   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> !fifo_full); // R6

   AST_FULL_SETS_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_state == 3'd4 || stat_state == 3'd5) && fifo_full) |=> stat_overflow); // R6

   AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_overflow |=> stat_overflow); // R6

   AST_DONE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state == 3'd5) |=> stat_group_done); // R7

   AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state == 3'd0 && sync_pulse) |=> !stat_group_done); // R7

   AST_MISSED_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state != 3'd0 && sync_pulse) |=> stat_missed); // R8

   AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_missed |=> stat_missed); // R8

   AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state == 3'd3) |-> (int'(wait_cnt) < TIMEOUT_CYC)); // R9

   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_timeout |=> stat_timeout); // R9

endmodule

bind acq_sequencer acq_sequencer_checker #(
   .NUM_CH      (NUM_CH),
   .TIMEOUT_CYC (TIMEOUT_CYC)
) u_acq_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .sync_pulse      (sync_pulse),
   .adc_ch_sel      (adc_ch_sel),
   .adc_start       (adc_start),
   .fifo_full       (fifo_full),
   .fifo_wr         (fifo_wr),
   .stat_state      (stat_state),
   .stat_group_done (stat_group_done),
   .stat_overflow   (stat_overflow),
   .stat_missed     (stat_missed),
   .stat_timeout    (stat_timeout)
);

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;

   localparam int N_CH  = 5;
   localparam int S_W   = 12;
   localparam int W_W   = 16;
   localparam int TMO   = 10;
   localparam int C_W   = $clog2(N_CH);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sync_pulse = 1'b0;
   logic [C_W-1:0] adc_ch_sel;
   logic           adc_start;
   logic           adc_ready = 1'b0;
   logic [S_W-1:0] adc_data = '0;
   logic           fifo_full;
   logic           fifo_wr;
   logic [W_W-1:0] fifo_data;
   logic           stat_fifo_full;
   logic [2:0]     stat_state;
   logic           stat_group_done;
   logic           stat_overflow;
   logic           stat_missed;
   logic           stat_timeout;

   int checks = 0;
   int errors = 0;

   int lat_tab [N_CH];
   int full_ch  = -1;
   bit full_crc = 1'b0;
   int group_id = 0;
   int waitcnt  = 0;
   int max_wait = 0;
   int mirror_bad = 0;
   bit trace_on = 1'b0;
   logic [2:0] prev_state = 3'd0;

   logic [W_W-1:0] got [$];
   logic [W_W-1:0] exp_q [$];
   int             trace [$];

   always #2 clk = ~clk;

   acq_sequencer #(
      .NUM_CH      (N_CH),
      .SAMPLE_W    (S_W),
      .WORD_W      (W_W),
      .TIMEOUT_CYC (TMO)
   ) u_acq_sequencer (
      .clk             (clk),
      .rst_n           (rst_n),
      .sync_pulse      (sync_pulse),
      .adc_ch_sel      (adc_ch_sel),
      .adc_start       (adc_start),
      .adc_ready       (adc_ready),
      .adc_data        (adc_data),
      .fifo_full       (fifo_full),
      .fifo_wr         (fifo_wr),
      .fifo_data       (fifo_data),
      .stat_fifo_full  (stat_fifo_full),
      .stat_state      (stat_state),
      .stat_group_done (stat_group_done),
      .stat_overflow   (stat_overflow),
      .stat_missed     (stat_missed),
      .stat_timeout    (stat_timeout)
   );

   // FIFO model: full only on the chosen store or on the check word
   assign fifo_full = ((full_ch >= 0) && (stat_state == 3'd4) && (int'(adc_ch_sel) == full_ch))
                   || (full_crc && (stat_state == 3'd5));

   function automatic logic [S_W-1:0] sample_val(int g, int ch);
      if (g == 2) return (ch % 2 == 0) ? 12'hFFF : 12'h800;
      return S_W'(((g * 733) + (ch * 1291) + 5) ^ (ch << 9));
   endfunction

   // Byte-wise reference CRC over one 16-bit word
   function automatic logic [15:0] crc_ref(logic [15:0] c, logic [15:0] w);
      for (int b = 1; b >= 0; b--) begin
         c = c ^ {w[b*8 +: 8], 8'h00};
         for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   // Converter model and per-clock monitor, all away from the active edge
   always @(negedge clk) begin
      if (stat_state == 3'd3) begin
         waitcnt   = waitcnt + 1;
         if (waitcnt > max_wait) max_wait = waitcnt;
         adc_ready = (lat_tab[adc_ch_sel] != 0) && (waitcnt == lat_tab[adc_ch_sel]);
         adc_data  = sample_val(group_id, int'(adc_ch_sel));
      end else begin
         waitcnt   = 0;
         adc_ready = 1'b0;
      end
      if (fifo_wr) got.push_back(fifo_data);
      if (stat_fifo_full !== fifo_full) mirror_bad++;
      if (trace_on && stat_state != prev_state) trace.push_back(int'(stat_state));
      prev_state = stat_state;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic build_expected(int tmo_ch);
      logic [15:0] c = 16'hFFFF;
      logic [15:0] w;
      exp_q.delete();
      for (int ch = 0; ch < N_CH; ch++) begin
         if (ch == tmo_ch) return;
         w = {4'h0, sample_val(group_id, ch)};
         if (ch != full_ch) begin
            exp_q.push_back(w);
            c = crc_ref(c, w);
         end
      end
      if (!full_crc) exp_q.push_back(c);
   endtask

   task automatic pulse();
      @(negedge clk) sync_pulse = 1'b1;
      @(negedge clk) sync_pulse = 1'b0;
   endtask

   task automatic wait_idle();
      while (stat_state != 3'd0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic compare_stream(string req);
      chk({req, " stream length"}, got.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got.size(); i++)
         chk({req, " stream word"}, got[i], exp_q[i]);
   endtask

   task automatic start_group(int g);
      group_id = g;
      got.delete();
      max_wait = 0;
      pulse();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N_CH; i++) lat_tab[i] = 1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state: R5 R7 R6 R8 R9
      chk("R5 reset state code", stat_state, 0);
      chk("R7 reset group done", stat_group_done, 0);
      chk("R6 reset overflow", stat_overflow, 0);
      chk("R8 reset missed", stat_missed, 0);
      chk("R9 reset timeout", stat_timeout, 0);
      chk("R3 reset no write", fifo_wr, 0);

      // R1: no pulse, no activity
      repeat (20) @(negedge clk);
      chk("R1 idle without pulse", stat_state, 0);
      chk("R1 no writes without pulse", got.size(), 0);

      // Group 1: unit latency, step trace R2 R5, stream R3 R4
      trace.delete();
      trace_on = 1'b1;
      start_group(1);
      chk("R1 pulse starts group", stat_state, 1);
      wait_idle();
      trace_on = 1'b0;
      build_expected(-1);
      compare_stream("R3 R4 group1");
      chk("R2 R5 trace length", trace.size(), 4 * N_CH + 2);
      for (int i = 0; i < 4 * N_CH && i < trace.size(); i++)
         chk("R2 R5 step order", trace[i], (i % 4) + 1);
      if (trace.size() == 4 * N_CH + 2) begin
         chk("R4 check word step", trace[4 * N_CH], 5);
         chk("R5 back to idle", trace[4 * N_CH + 1], 0);
      end
      chk("R7 done after group", stat_group_done, 1);
      chk("R8 no missed yet", stat_missed, 0);

      // Group 2: mixed latencies, extreme sample values, trigger during group
      for (int i = 0; i < N_CH; i++) lat_tab[i] = i + 1;
      start_group(2);
      chk("R7 done cleared by pulse", stat_group_done, 0);
      while (stat_state != 3'd3) @(negedge clk);
      pulse();
      chk("R8 missed set", stat_missed, 1);
      wait_idle();
      build_expected(-1);
      compare_stream("R8 R3 group2");
      chk("R7 done group2", stat_group_done, 1);

      // Group 3: FIFO full on channel 2
      for (int i = 0; i < N_CH; i++) lat_tab[i] = 2;
      full_ch = 2;
      start_group(3);
      wait_idle();
      build_expected(-1);
      compare_stream("R6 dropped sample");
      chk("R6 overflow set", stat_overflow, 1);
      chk("R7 done group3", stat_group_done, 1);
      full_ch = -1;

      // Group 4: FIFO full on the check word
      full_crc = 1'b1;
      start_group(4);
      wait_idle();
      build_expected(-1);
      compare_stream("R6 dropped check word");
      chk("R6 overflow sticky", stat_overflow, 1);
      full_crc = 1'b0;

      // Group 5: answer on the last allowed wait cycle
      lat_tab[1] = TMO;
      start_group(5);
      wait_idle();
      build_expected(-1);
      compare_stream("R9 boundary accepted");
      chk("R9 no timeout at limit", stat_timeout, 0);
      chk("R9 max wait at limit", max_wait, TMO);

      // Group 6: channel 3 never answers
      lat_tab[1] = 1;
      lat_tab[3] = 0;
      start_group(6);
      wait_idle();
      build_expected(3);
      compare_stream("R9 aborted group");
      chk("R9 timeout set", stat_timeout, 1);
      chk("R9 wait length", max_wait, TMO);
      chk("R9 no done on abort", stat_group_done, 0);
      chk("R9 idle after abort", stat_state, 0);

      // Group 7: recovery after abort
      lat_tab[3] = 3;
      start_group(7);
      wait_idle();
      build_expected(-1);
      compare_stream("R4 group7");
      chk("R7 done group7", stat_group_done, 1);
      chk("R9 timeout sticky", stat_timeout, 1);

      chk("R5 status mirrors full", mirror_bad, 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule